// File: doc/BRIEF.md
# Clock Frequency Measurement Counter

This block estimates the frequency of an unknown clock by comparing it with a reference clock of known frequency. A down-counter in the reference domain opens a measurement window lasting a programmed number of reference cycles. A 24-bit up-counter in the measured domain counts edges of the unknown clock while that window is open. Software later divides the two counts to get the unknown frequency: f_meas ≈ f_ref × result / programmed count.

Software starts a run by presenting a non-zero reference count together with a one-cycle start pulse. It then polls the done flag and reads the result. The window-open level reaches the measured domain through a two-flop synchronizer, and a copy of it returns to the reference domain through another two-flop synchronizer. Done is raised only after the returned copy has risen and then fallen. At that point the measured-domain counter has stopped and its value can be read safely.

The busy output stays high for the whole run. A power controller uses it to hold off entry into a deep low-power state while a run is in progress.

Top module: `clkcal_meter`

## Requirements
- R1: After reset, busy_o is 0, done_o is 0 and meas_count_o is 0.
- R2: A start_i pulse with a non-zero ref_count_i while busy_o is 0 is accepted. From the next reference edge, busy_o is 1 and done_o is 0.
- R3: A start_i pulse with ref_count_i equal to 0 is ignored. busy_o stays 0, and done_o and meas_count_o keep their values.
- R4: A start_i pulse while busy_o is 1 is ignored. The run keeps its original count, and the result matches that original count.
- R5: For a programmed count N, meas_count_o at done equals N × f_meas / f_ref within ±3 counts. This margin allows for synchronizer skew.
- R6: The window lasts exactly N reference cycles. done_o therefore rises no earlier than N+1 reference edges after the accepting edge.
- R7: While done_o stays high, meas_count_o does not change.
- R8: The measured-domain counter saturates at its all-ones value instead of wrapping to zero.
- R9: busy_o and done_o are never both 1. busy_o falls only on the edge where done_o rises, so deep low-power entry is held off for the whole run.
- R10: done_o stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock of known frequency |
| rst_ref_n | input | 1 | Synchronous active-low reset, reference domain |
| clk_meas | input | 1 | Clock under measurement |
| rst_meas_n | input | 1 | Synchronous active-low reset, measured domain |
| start_i | input | 1 | One-cycle start request (reference domain) |
| ref_count_i | input | REF_W | Window length in reference cycles; 0 is invalid |
| busy_o | output | 1 | Run in progress; blocks deep low-power entry |
| done_o | output | 1 | Sticky flag: result is ready and frozen |
| meas_count_o | output | MEAS_W | Measured-clock cycles counted in the window |

## Verification
The bench checks each result at one of three points, each tied to a reference edge.

- **Start response (R2):** busy_o and the cleared done_o are due one reference edge after the start pulse is captured. The bench samples them on the falling edge that follows.
- **Run result (R5, R6):** done_o and the result arrive after the N-cycle window, plus the forward synchronizer latency, plus the return synchronizer latency. That total depends on the ratio between the two clocks, so the bench does not fix a cycle number. Instead, a monitor waits for the rising edge of done_o, takes the oldest expected entry from the scoreboard queue, and applies two checks:
  - the count must be within the stated tolerance;
  - the elapsed cycle count must be at least N+1.
- **Ignored starts and frozen result (R3, R4, R7):** these are checked a fixed number of reference cycles after the stimulus, on falling edges.

// File: rtl/clkcal_pkg.sv
// Package: shared state encoding for the frequency measurement counter.
// Assumes: nothing beyond IEEE 1800-2017.
package clkcal_pkg;

    // Reference-domain control phases.
    typedef enum logic [1:0] {
        CAL_IDLE  = 2'd0,   // waiting for an accepted start
        CAL_OPEN  = 2'd1,   // window open, reference counter running
        CAL_DRAIN = 2'd2    // window closed, waiting for the return handshake
    } cal_phase_e;

endpackage

// File: rtl/clkcal_sync.sv
// Module: clkcal_sync
// Multi-flop level synchronizer. It carries one slowly changing level into the
// destination clock domain.
// Assumes: the source level is held for longer than one destination period
// plus the setup and hold window, and the reset is synchronous to dst_clk.
module clkcal_sync #(
    parameter int STAGES = 2
) (
    input  logic dst_clk,
    input  logic dst_rst_n,
    input  logic level_i,
    output logic level_o
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single stage: capture the level directly.
            always_ff @(posedge dst_clk) begin
                if (!dst_rst_n) chain_q <= '0;
                else            chain_q <= level_i;
            end
        end else begin : g_multi
            // Multi stage: shift the level along the chain.
            always_ff @(posedge dst_clk) begin
                if (!dst_rst_n) chain_q <= '0;
                else            chain_q <= {chain_q[LAST-1:0], level_i};
            end
        end
    endgenerate

    assign level_o = chain_q[LAST];

endmodule

// File: rtl/clkcal_ref_ctrl.sv
// Module: clkcal_ref_ctrl
// Reference-domain controller. It accepts a start, runs the down-counting
// window, waits until the measured domain has seen the window open and then
// close, and then raises a sticky done flag.
// Assumes: win_ack_i is the window level returned through a synchronizer.
// The window must span at least a few measured-clock periods, otherwise the
// return handshake never rises and the run does not finish.
module clkcal_ref_ctrl
    import clkcal_pkg::*;
#(
    parameter int REF_W = 16
) (
    input  logic             clk_ref,
    input  logic             rst_ref_n,
    input  logic             start_i,
    input  logic [REF_W-1:0] ref_count_i,
    input  logic             win_ack_i,
    output logic             window_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [REF_W-1:0] LAST_TICK = REF_W'(1);

    cal_phase_e       phase_q;
    logic [REF_W-1:0] remain_q;
    logic             ack_seen_q;
    logic             done_q;
    logic             accept;
    logic             drain_exit;

    // A start is taken only when idle and with a valid, non-zero count.
    always_comb begin
        accept = (phase_q == CAL_IDLE) && start_i && (ref_count_i != '0);
    end

    // The drain ends once the return path has risen at least once and is low again.
    always_comb begin
        drain_exit = (phase_q == CAL_DRAIN) && ack_seen_q && !win_ack_i;
    end

    // Phase sequencing: idle -> open -> drain -> idle.
    always_ff @(posedge clk_ref) begin
        if (!rst_ref_n) begin
            phase_q <= CAL_IDLE;
        end else begin
            unique case (phase_q)
                CAL_IDLE:  if (accept)                phase_q <= CAL_OPEN;
                CAL_OPEN:  if (remain_q == LAST_TICK) phase_q <= CAL_DRAIN;
                CAL_DRAIN: if (drain_exit)            phase_q <= CAL_IDLE;
                default:                              phase_q <= CAL_IDLE;
            endcase
        end
    end

    // Window length counter: loaded on accept, decremented while open.
    always_ff @(posedge clk_ref) begin
        if (!rst_ref_n) begin
            remain_q <= '0;
        end else if (accept) begin
            remain_q <= ref_count_i;
        end else if (phase_q == CAL_OPEN) begin
            remain_q <= remain_q - LAST_TICK;
        end
    end

    // Remember that the measured domain has acknowledged the open window.
    always_ff @(posedge clk_ref) begin
        if (!rst_ref_n) begin
            ack_seen_q <= 1'b0;
        end else if (accept) begin
            ack_seen_q <= 1'b0;
        end else if (phase_q != CAL_IDLE && win_ack_i) begin
            ack_seen_q <= 1'b1;
        end
    end

    // Sticky done flag: cleared on accept, set when the drain completes.
    always_ff @(posedge clk_ref) begin
        if (!rst_ref_n) begin
            done_q <= 1'b0;
        end else if (accept) begin
            done_q <= 1'b0;
        end else if (drain_exit) begin
            done_q <= 1'b1;
        end
    end

    assign window_o = (phase_q == CAL_OPEN);
    assign busy_o   = (phase_q != CAL_IDLE);
    assign done_o   = done_q;

endmodule

// File: rtl/clkcal_meas_cnt.sv
// Module: clkcal_meas_cnt
// Measured-domain edge counter. It restarts at one on the first cycle the
// synchronized window is seen open, increments while the window stays open,
// saturates at all ones, and holds its value while the window is closed.
// Assumes: win_i is already synchronized to clk_meas.
module clkcal_meas_cnt #(
    parameter int MEAS_W = 24
) (
    input  logic              clk_meas,
    input  logic              rst_meas_n,
    input  logic              win_i,
    output logic [MEAS_W-1:0] count_o
);

    localparam logic [MEAS_W-1:0] CNT_MAX = {MEAS_W{1'b1}};
    localparam logic [MEAS_W-1:0] CNT_ONE = MEAS_W'(1);

    logic              win_d_q;
    logic [MEAS_W-1:0] count_q;
    logic              win_rise;

    // Detect the opening of a new window.
    always_comb begin
        win_rise = win_i && !win_d_q;
    end

    // Delay the window by one cycle for edge detection.
    always_ff @(posedge clk_meas) begin
        if (!rst_meas_n) win_d_q <= 1'b0;
        else             win_d_q <= win_i;
    end

    // Count while open, clamp at the maximum, and restart on each new window.
    always_ff @(posedge clk_meas) begin
        if (!rst_meas_n) begin
            count_q <= '0;
        end else if (win_rise) begin
            count_q <= CNT_ONE;
        end else if (win_i && count_q != CNT_MAX) begin
            count_q <= count_q + CNT_ONE;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/clkcal_meter.sv
// Module: clkcal_meter (top)
// Two-clock frequency measurement. The reference domain owns the window and
// the control. The window level crosses to the measured domain and its echo
// crosses back, so done rises only once the measured counter is frozen.
// Assumes: meas_count_o is read in the reference domain only while done_o is
// high, when it is quasi-static.
module clkcal_meter #(
    parameter int REF_W     = 16,
    parameter int MEAS_W    = 24,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk_ref,
    input  logic              rst_ref_n,
    input  logic              clk_meas,
    input  logic              rst_meas_n,
    input  logic              start_i,
    input  logic [REF_W-1:0]  ref_count_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [MEAS_W-1:0] meas_count_o
);

    logic window_ref;
    logic window_meas;
    logic window_ack;

    clkcal_ref_ctrl #(.REF_W(REF_W)) u_ctrl (
        .clk_ref     (clk_ref),
        .rst_ref_n   (rst_ref_n),
        .start_i     (start_i),
        .ref_count_i (ref_count_i),
        .win_ack_i   (window_ack),
        .window_o    (window_ref),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    clkcal_sync #(.STAGES(SYNC_DEPTH)) u_sync_fwd (
        .dst_clk   (clk_meas),
        .dst_rst_n (rst_meas_n),
        .level_i   (window_ref),
        .level_o   (window_meas)
    );

    clkcal_sync #(.STAGES(SYNC_DEPTH)) u_sync_back (
        .dst_clk   (clk_ref),
        .dst_rst_n (rst_ref_n),
        .level_i   (window_meas),
        .level_o   (window_ack)
    );

    clkcal_meas_cnt #(.MEAS_W(MEAS_W)) u_cnt (
        .clk_meas   (clk_meas),
        .rst_meas_n (rst_meas_n),
        .win_i      (window_meas),
        .count_o    (meas_count_o)
    );

endmodule

// File: rtl/clkcal_meter_chk.sv
// Module: clkcal_meter_chk
// Port-level protocol checker bound to clkcal_meter.
// Assumes: the same clocks and resets as the top module.
module clkcal_meter_chk #(
    parameter int REF_W  = 16,
    parameter int MEAS_W = 24
) (
    input logic              clk_ref,
    input logic              rst_ref_n,
    input logic              clk_meas,
    input logic              rst_meas_n,
    input logic              start_i,
    input logic [REF_W-1:0]  ref_count_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [MEAS_W-1:0] meas_count_o
);

    localparam logic [MEAS_W-1:0] CNT_MAX = {MEAS_W{1'b1}};

    assert_start_accept_R2: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        (start_i && ref_count_i != '0 && !busy_o) |=> (busy_o && !done_o));

    assert_zero_ignored_R3: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        (start_i && ref_count_i == '0 && !busy_o) |=> (!busy_o && done_o == $past(done_o)));

    assert_frozen_result_R7: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        (done_o && $past(done_o)) |-> $stable(meas_count_o));

    assert_no_wrap_R8: assert property (@(posedge clk_meas) disable iff (!rst_meas_n)
        (meas_count_o == CNT_MAX) |=> (meas_count_o == CNT_MAX || meas_count_o == MEAS_W'(1)));

    assert_busy_done_excl_R9: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        !(busy_o && done_o));

    assert_busy_release_R9: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        $fell(busy_o) |-> done_o);

    assert_done_sticky_R10: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        (done_o && !(start_i && ref_count_i != '0)) |=> done_o);

endmodule

bind clkcal_meter clkcal_meter_chk #(.REF_W(REF_W), .MEAS_W(MEAS_W)) u_chk (
    .clk_ref      (clk_ref),
    .rst_ref_n    (rst_ref_n),
    .clk_meas     (clk_meas),
    .rst_meas_n   (rst_meas_n),
    .start_i      (start_i),
    .ref_count_i  (ref_count_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .meas_count_o (meas_count_o)
);

// File: tb/clkcal_meter_tb.sv
`timescale 1ns/1ps
module clkcal_meter_tb;

    localparam real REF_PERIOD = 10.0;
    localparam int  REF_W      = 16;
    localparam int  MEAS_W     = 24;
    localparam int  SAT_W      = 8;
    localparam int  SAT_MAX    = (1 << SAT_W) - 1;
    localparam int  TOL        = 3;
    localparam int  WDOG       = 150000;

    typedef struct {
        int n;
        int exp_cnt;
        int exp_sat;
        bit sat_exact;
    } exp_item_t;

    logic clk_ref = 1'b0;
    logic clk_meas = 1'b0;
    logic rst_ref_n = 1'b0;
    logic rst_meas_n = 1'b0;
    logic start_i = 1'b0;
    logic [REF_W-1:0] ref_count_i = '0;
    logic busy_o, done_o, busy_s, done_s;
    logic [MEAS_W-1:0] cnt_o;
    logic [SAT_W-1:0] cnt_s;
    real meas_half = 3.5;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    longint cyc = 0;
    longint t_acc = 0;
    exp_item_t sb[$];

    always #(REF_PERIOD / 2.0) clk_ref = ~clk_ref;

    initial begin
        forever #(meas_half) clk_meas = ~clk_meas;
    end

    always @(posedge clk_ref) cyc <= cyc + 1;

    clkcal_meter #(.REF_W(REF_W), .MEAS_W(MEAS_W)) u_dut (
        .clk_ref(clk_ref), .rst_ref_n(rst_ref_n), .clk_meas(clk_meas), .rst_meas_n(rst_meas_n),
        .start_i(start_i), .ref_count_i(ref_count_i),
        .busy_o(busy_o), .done_o(done_o), .meas_count_o(cnt_o));

    clkcal_meter #(.REF_W(REF_W), .MEAS_W(SAT_W)) u_dut_sat (
        .clk_ref(clk_ref), .rst_ref_n(rst_ref_n), .clk_meas(clk_meas), .rst_meas_n(rst_meas_n),
        .start_i(start_i), .ref_count_i(ref_count_i),
        .busy_o(busy_s), .done_o(done_s), .meas_count_o(cnt_s));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver: push the expected result, then pulse start.
    task automatic launch(input int n);
        exp_item_t it;
        real e;
        e = real'(n) * REF_PERIOD / (2.0 * meas_half);
        it.n = n;
        it.exp_cnt = int'(e);
        it.sat_exact = (e > real'(SAT_MAX + 10));
        it.exp_sat = it.sat_exact ? SAT_MAX : int'(e);
        sb.push_back(it);
        @(negedge clk_ref);
        start_i = 1'b1;
        ref_count_i = REF_W'(n);
        @(negedge clk_ref);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2", "busy after accept", busy_o, 1);
        check(done_o == 1'b0, "R2", "done cleared on accept", done_o, 0);
    endtask

    task automatic wait_done_and_hold();
        logic [MEAS_W-1:0] snap;
        while (!done_o) @(negedge clk_ref);
        snap = cnt_o;
        repeat (20) @(negedge clk_ref);
        check(cnt_o == snap, "R7", "result frozen while done", cnt_o, snap);
        check(done_o == 1'b1, "R10", "done still high", done_o, 1);
    endtask

    // Monitor: on each rise of done, pop and compare.
    initial begin
        logic pb, pd;
        pb = 1'b0;
        pd = 1'b0;
        forever begin
            @(negedge clk_ref);
            if (busy_o && !pb) t_acc = cyc;
            if (done_o && !pd) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5", "unexpected done", 1, 0);
                end else begin
                    exp_item_t it;
                    int d;
                    it = sb.pop_front();
                    d = int'(cnt_o) - it.exp_cnt;
                    check(d <= TOL && d >= -TOL, "R5", "count ratio", cnt_o, it.exp_cnt);
                    check(cyc - t_acc >= it.n + 1, "R6", "window length", cyc - t_acc, it.n + 1);
                    check(busy_o == 1'b0, "R9", "busy released with done", busy_o, 0);
                    if (it.sat_exact)
                        check(int'(cnt_s) == SAT_MAX, "R8", "saturated count", cnt_s, SAT_MAX);
                    else
                        check(int'(cnt_s) - it.exp_sat <= TOL && it.exp_sat - int'(cnt_s) <= TOL,
                              "R8", "narrow counter below max", cnt_s, it.exp_sat);
                end
            end
            pb = busy_o;
            pd = done_o;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WDOG) @(posedge clk_ref);
        check(1'b0, "R6", "watchdog expired", cyc, WDOG);
        finish_run();
    end

    initial begin
        logic [MEAS_W-1:0] snap;
        repeat (10) @(negedge clk_ref);
        rst_ref_n = 1'b1;
        rst_meas_n = 1'b1;
        @(negedge clk_ref);
        check(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);
        check(done_o == 1'b0, "R1", "reset done", done_o, 0);
        check(cnt_o == '0, "R1", "reset count", cnt_o, 0);

        // Fast measured clock, mid-size window (narrow copy saturates).
        launch(1000);
        wait_done_and_hold();

        // A zero count must be ignored.
        snap = cnt_o;
        @(negedge clk_ref);
        start_i = 1'b1;
        ref_count_i = '0;
        @(negedge clk_ref);
        start_i = 1'b0;
        repeat (3) @(negedge clk_ref);
        check(busy_o == 1'b0, "R3", "zero count not accepted", busy_o, 0);
        check(done_o == 1'b1, "R3", "done kept after zero count", done_o, 1);
        check(cnt_o == snap, "R3", "count kept after zero count", cnt_o, snap);

        // Long window with a second start in the middle that must be ignored.
        launch(40000);
        repeat (100) @(negedge clk_ref);
        start_i = 1'b1;
        ref_count_i = REF_W'(5);
        @(negedge clk_ref);
        start_i = 1'b0;
        repeat (20) @(negedge clk_ref);
        check(busy_o == 1'b1, "R4", "busy kept after restart attempt", busy_o, 1);
        wait_done_and_hold();

        // Slower measured clock.
        meas_half = 11.5;
        launch(500);
        wait_done_and_hold();

        // Shortest legal window.
        meas_half = 3.5;
        launch(1);
        wait_done_and_hold();

        repeat (5) @(negedge clk_ref);
        check(sb.size() == 0, "R5", "all results delivered", sb.size(), 0);
        finish_run();
    end

endmodule